// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block produces and verifies the single even-parity bit that protects a 32-bit multiplexed address/data bus together with its 4-bit command/byte-enable bus. Whenever the agent drives an address or data word, the block computes the parity bit from that word. It then drives the bit onto the bus one clock later, together with an output enable. Whenever the agent receives an address or data word, the block computes the parity of that word. One clock later it compares the result with the parity bit sampled from the bus.

A mismatch in a received data phase is reported on an active-low data-error output. A mismatch in a received address phase is treated as a serious system fault and is reported on a separate active-low system-error output. Each output has its own enable input. A sticky detected-error flag records every mismatch whether or not the enables are set. It is cleared by pulsing a write-one-to-clear input. The bus protocol sequencer supplies the phase qualifiers and is outside this block.

Top module: `bus_parity_unit`

## Requirements
- R1: The clock after `drive_i` is high, `par_o` equals the XOR of the `ad_i[31:0]` and `cbe_i[3:0]` values present with `drive_i`, so the count of ones across those 36 bits plus `par_o` is even.
- R2: `par_oe_o` is high in exactly the clock that follows a clock with `drive_i` high, and low otherwise.
- R3: A received data phase (`data_vld_i` high in clock t) whose `par_i` in clock t+1 differs from the even parity of the word drives `perr_no` low in clock t+2 for one clock, provided `perr_en_i` is high in clock t+1.
- R4: With `perr_en_i` low in clock t+1, a data-phase mismatch leaves `perr_no` high.
- R5: A received address phase (`addr_vld_i` high in clock t) with a parity mismatch in clock t+1 drives `serr_no` low for one clock in clock t+2 when `serr_en_i` is high in clock t+1, and leaves it high when `serr_en_i` is low.
- R6: Address-phase mismatches never drive `perr_no` low, and data-phase mismatches never drive `serr_no` low.
- R7: A received phase whose `par_i` matches the even parity of the word raises neither error output and does not set the status flag.
- R8: Any address-phase or data-phase mismatch sets `par_err_sts_o` in clock t+2, whatever the state of both enables, and the flag stays set.
- R9: `clr_sts_i` high in a clock clears `par_err_sts_o` from the next clock on. If a mismatch is detected in the same clock, the flag stays set.
- R10: While `rst_ni` is low, `par_o` and `par_oe_o` are 0, `perr_no` and `serr_no` are 1, and `par_err_sts_o` is 0.
- R11: When neither `addr_vld_i` nor `data_vld_i` was high in the previous clock, `par_i` is ignored: no error output and no status change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ad_i | input | 32 | Address/data bus value, driven or received |
| cbe_i | input | 4 | Command/byte-enable bus value |
| drive_i | input | 1 | Agent drives address or data this clock |
| addr_vld_i | input | 1 | Agent receives an address phase this clock |
| data_vld_i | input | 1 | Agent receives a data phase this clock |
| par_i | input | 1 | Parity bit sampled from the bus |
| perr_en_i | input | 1 | Enables data-error reporting |
| serr_en_i | input | 1 | Enables system-error reporting |
| clr_sts_i | input | 1 | Write-one-to-clear for the status flag |
| par_o | output | 1 | Generated parity bit |
| par_oe_o | output | 1 | Output enable for `par_o` |
| perr_no | output | 1 | Data parity error, active low |
| serr_no | output | 1 | System error on address parity, active low, active low |
| par_err_sts_o | output | 1 | Sticky detected-parity-error flag |

## Verification
The status flag can receive a new detection and a clear request in the same clock. The bench provokes this by asserting `clr_sts_i` in the very clock a corrupted parity bit arrives for a data phase. It judges the result by the flag two clocks after the phase: the flag must still be set, and a plain clear afterwards must then take effect. A second overlap is an address phase followed at once by a data phase, both corrupted. The bench checks that `serr_no` and `perr_no` each pulse once, in consecutive clocks, and each on its own output.

// File: rtl/bpar_pkg.sv
package bpar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  typedef struct packed {
    phase_e kind;
    logic   calc;
  } chk_stage_t;
endpackage

// File: rtl/bpar_tree.sv
module bpar_tree #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  output logic             par_o
);
  localparam int LANE_W = AD_W / CBE_W;

  logic [CBE_W-1:0] lane_par;

  // one byte lane plus its enable bit per leaf
  for (genvar g = 0; g < CBE_W; g++) begin : g_lane
    assign lane_par[g] = (^ad_i[g*LANE_W +: LANE_W]) ^ cbe_i[g];
  end

  assign par_o = ^lane_par;

  initial begin
    AST_LANE_SPLIT: assert (LANE_W * CBE_W == AD_W); // R1
  end
endmodule

// File: rtl/bpar_gen.sv
module bpar_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drive_i,
  input  logic calc_i,
  output logic par_o,
  output logic par_oe_o
);
  logic par_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q  <= drive_i;
      par_q <= drive_i ? calc_i : 1'b0;
    end
  end

  assign par_o    = par_q;
  assign par_oe_o = oe_q;

  AST_OE_AFTER_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_i |=> par_oe_o); // R2
  AST_OE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_i |=> !par_oe_o); // R2
  AST_PAR_ONLY_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_o |-> par_oe_o); // R1
endmodule

// File: rtl/bpar_chk.sv
module bpar_chk
  import bpar_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic addr_vld_i,
  input  logic data_vld_i,
  input  logic calc_i,
  input  logic par_i,
  input  logic perr_en_i,
  input  logic serr_en_i,
  input  logic clr_sts_i,
  output logic perr_no,
  output logic serr_no,
  output logic sts_o
);
  chk_stage_t stage_q;
  phase_e     kind_d;
  logic       mism;
  logic       perr_q, serr_q, sts_q;

  // address qualifier wins if both are raised
  always_comb begin
    if (addr_vld_i)      kind_d = PH_ADDR;
    else if (data_vld_i) kind_d = PH_DATA;
    else                 kind_d = PH_IDLE;
  end

  assign mism = (stage_q.kind != PH_IDLE) && (stage_q.calc != par_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '{kind: PH_IDLE, calc: 1'b0};
      perr_q  <= 1'b0;
      serr_q  <= 1'b0;
      sts_q   <= 1'b0;
    end else begin
      stage_q <= '{kind: kind_d, calc: calc_i};
      perr_q  <= mism && (stage_q.kind == PH_DATA) && perr_en_i;
      serr_q  <= mism && (stage_q.kind == PH_ADDR) && serr_en_i;
      if (mism)           sts_q <= 1'b1;
      else if (clr_sts_i) sts_q <= 1'b0;
    end
  end

  assign perr_no = ~perr_q;
  assign serr_no = ~serr_q;
  assign sts_o   = sts_q;

  AST_PERR_FROM_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_no |-> $past(data_vld_i, 2)); // R6
  AST_SERR_FROM_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !serr_no |-> $past(addr_vld_i, 2)); // R6
  AST_PERR_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_no |-> $past(perr_en_i)); // R4
  AST_SERR_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !serr_no |-> $past(serr_en_i)); // R5
  AST_STS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mism |=> sts_o); // R8
  AST_STS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_sts_i && !mism) |=> !sts_o); // R9
  AST_ERR_MEANS_STS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!perr_no || !serr_no) |-> sts_o); // R8
endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  input  logic             drive_i,
  input  logic             addr_vld_i,
  input  logic             data_vld_i,
  input  logic             par_i,
  input  logic             perr_en_i,
  input  logic             serr_en_i,
  input  logic             clr_sts_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             perr_no,
  output logic             serr_no,
  output logic             par_err_sts_o
);
  logic calc;

  // one tree serves both directions: the agent never drives and receives together
  bpar_tree #(.AD_W(AD_W), .CBE_W(CBE_W)) u_tree (
    .ad_i  (ad_i),
    .cbe_i (cbe_i),
    .par_o (calc)
  );

  bpar_gen u_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .drive_i  (drive_i),
    .calc_i   (calc),
    .par_o    (par_o),
    .par_oe_o (par_oe_o)
  );

  bpar_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_vld_i (addr_vld_i),
    .data_vld_i (data_vld_i),
    .calc_i     (calc),
    .par_i      (par_i),
    .perr_en_i  (perr_en_i),
    .serr_en_i  (serr_en_i),
    .clr_sts_i  (clr_sts_i),
    .perr_no    (perr_no),
    .serr_no    (serr_no),
    .sts_o      (par_err_sts_o)
  );
endmodule

// File: tb/bus_parity_unit_bench.sv
`timescale 1ns/1ps
module bus_parity_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic        drive = 1'b0, addr_vld = 1'b0, data_vld = 1'b0, par_in = 1'b0;
  logic        perr_en = 1'b1, serr_en = 1'b1, clr = 1'b0;
  logic        par_out, par_oe, perr_n, serr_n, sts;

  int n_chk = 0;
  int n_fail = 0;
  bit sts_m = 1'b0;

  always #2.5 clk = ~clk;

  bus_parity_unit u_bus_parity_unit (
    .clk_i(clk), .rst_ni(rst_n), .ad_i(ad), .cbe_i(cbe), .drive_i(drive),
    .addr_vld_i(addr_vld), .data_vld_i(data_vld), .par_i(par_in),
    .perr_en_i(perr_en), .serr_en_i(serr_en), .clr_sts_i(clr),
    .par_o(par_out), .par_oe_o(par_oe), .perr_no(perr_n), .serr_no(serr_n),
    .par_err_sts_o(sts)
  );

  // {expected even parity, cbe, ad}
  localparam logic [36:0] VEC [8] = '{
    {1'b0, 4'h0, 32'h0000_0000},
    {1'b0, 4'hF, 32'hFFFF_FFFF},
    {1'b1, 4'h1, 32'h0000_0000},
    {1'b1, 4'h0, 32'h0000_0001},
    {1'b0, 4'hA, 32'h5A5A_5A5A},
    {1'b1, 4'h3, 32'h1234_5678},
    {1'b0, 4'h8, 32'h8000_0000},
    {1'b0, 4'h5, 32'hDEAD_BEEF}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // receive one phase, return expected outputs two and three clocks later
  task automatic rx(input bit is_addr, input logic [36:0] v, input bit bad,
                    input bit pe, input bit se, input bit clr_same);
    @(negedge clk);
    ad = v[31:0]; cbe = v[35:32]; addr_vld = is_addr; data_vld = !is_addr;
    @(negedge clk);
    addr_vld = 0; data_vld = 0; par_in = v[36] ^ bad;
    perr_en = pe; serr_en = se; clr = clr_same;
    @(negedge clk);
    clr = 0; par_in = 0;
    if (bad) sts_m = 1'b1;
    else if (clr_same) sts_m = 1'b0;
    check(is_addr ? "R5" : "R3", is_addr ? serr_n : perr_n,
          !(bad && (is_addr ? se : pe)));
    check("R6", is_addr ? perr_n : serr_n, 1'b1);
    check(bad ? "R8" : "R7", sts, sts_m);
    @(negedge clk);
    check("R3_R5 pulse width", perr_n & serr_n, 1'b1);
  endtask

  task automatic clear_sts();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0; sts_m = 0;
    check("R9 clear", sts, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset values
    check("R10 par_o", par_out, 1'b0);
    check("R10 par_oe_o", par_oe, 1'b0);
    check("R10 perr_no", perr_n, 1'b1);
    check("R10 serr_no", serr_n, 1'b1);
    check("R10 sts", sts, 1'b0);
    rst_n = 1;

    // table walk: generate back to back, then receive each with good parity
    foreach (VEC[i]) begin
      @(negedge clk);
      if (i > 0) begin
        check("R2 oe", par_oe, 1'b1);
        check("R1 parity", par_out, VEC[i-1][36]);
      end
      drive = 1; ad = VEC[i][31:0]; cbe = VEC[i][35:32];
    end
    @(negedge clk);
    check("R2 oe", par_oe, 1'b1);
    check("R1 parity", par_out, VEC[7][36]);
    drive = 0; ad = 32'hFFFF_FFFE;
    @(negedge clk);
    check("R2 idle oe", par_oe, 1'b0);
    foreach (VEC[i]) rx(i[0], VEC[i], 1'b0, 1'b1, 1'b1, 1'b0); // R7

    // data error, enabled / masked
    rx(1'b0, VEC[5], 1'b1, 1'b1, 1'b1, 1'b0); // R3
    clear_sts();
    rx(1'b0, VEC[2], 1'b1, 1'b0, 1'b1, 1'b0); // R4, R8 regardless of enable
    clear_sts();
    // address error, enabled / masked
    rx(1'b1, VEC[4], 1'b1, 1'b1, 1'b1, 1'b0); // R5, R6
    clear_sts();
    rx(1'b1, VEC[3], 1'b1, 1'b1, 1'b0, 1'b0); // R5 masked, R8
    clear_sts();

    // R11: bad parity with no qualifier
    @(negedge clk); ad = 32'h0000_0001; cbe = 0;
    @(negedge clk); par_in = 1'b0;
    @(negedge clk); par_in = 1'b0;
    check("R11 perr", perr_n, 1'b1);
    check("R11 serr", serr_n, 1'b1);
    @(negedge clk);
    check("R11 sts", sts, 1'b0);

    // R9 collision: set already, clear in the detection clock, set wins
    rx(1'b0, VEC[0], 1'b1, 1'b1, 1'b1, 1'b0);
    rx(1'b0, VEC[6], 1'b1, 1'b1, 1'b1, 1'b1);
    check("R9 set wins", sts, 1'b1);
    clear_sts();

    // address then data back to back, both corrupted
    @(negedge clk); ad = VEC[5][31:0]; cbe = VEC[5][35:32]; addr_vld = 1;
    perr_en = 1; serr_en = 1;
    @(negedge clk); par_in = ~VEC[5][36];
    ad = VEC[2][31:0]; cbe = VEC[2][35:32]; addr_vld = 0; data_vld = 1;
    @(negedge clk); par_in = ~VEC[2][36]; data_vld = 0;
    check("R5 b2b serr", serr_n, 1'b0);
    check("R6 b2b perr idle", perr_n, 1'b1);
    @(negedge clk); par_in = 0;
    check("R3 b2b perr", perr_n, 1'b0);
    check("R6 b2b serr idle", serr_n, 1'b1);
    @(negedge clk);
    check("R3 b2b release", perr_n, 1'b1);
    check("R8 b2b sts", sts, 1'b1);

    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog all-R actual=running expected=finished");
    summary();
    $finish;
  end
endmodule